// File: doc/BRIEF.md
# Stepped Processing Clock Controller

This block turns a free-running base clock into a gated clock-enable for user processing logic. A small write-only register port sets the controller's mode. In free-running mode the enable stays high on every cycle. In hold mode it is low. A counted burst issues an exact number of enabled cycles and then stops. In push-triggered mode, each write into the host input queue releases a preset burst. While the enable is active, a processing element can also request a stop by pulling its halt line low.

A host memory arbiter can freeze the enable at any time with a pause request. The remaining burst count is kept and resumes when the pause ends. A one-cycle completion pulse marks the end of every counted burst and serves as an interrupt source. The busy output lets the host either poll for completion or carry on without waiting.

Top module: `stepclk_ctrl`

## Requirements
- R1: After synchronous active-high reset, `pclk_en`, `busy` and `step_done` are low, the mode is hold and every halt line is disarmed. A falling halt line while free-running then has no effect.
- R2: Writing mode code 1 to address 0 makes `pclk_en` high on every following cycle that has no pause.
- R3: Writing mode code 0 or 3 to address 0 drops `pclk_en` in the next cycle and clears any remaining burst count without a `step_done` pulse. Mode code 2 selects push-triggered mode and holds the enable low while idle.
- R4: Writing a nonzero value N to address 1 while idle gives exactly N enabled cycles, starting in the cycle after the write. `busy` is high through those cycles. A nonzero write to address 1 is ignored while free-running. A write of zero is ignored.
- R5: A write to address 1 while a burst is running is ignored, and the burst completes with its original length.
- R6: In push-triggered mode, each `fifo_push` while idle starts a burst whose length is the value last written to address 2. That value persists across pushes. A push during a burst, or outside push-triggered mode, is ignored.
- R7: While the enable is active, a falling edge on a halt line armed by bit k of address 3 allows exactly three more enabled cycles. After that, free-running mode and any burst count are cleared.
- R8: A falling edge on a halt line whose arm bit is zero has no effect on the enable.
- R9: While `pause_req` is high, `pclk_en` is low and the burst count does not change. When the pause ends, the remaining count resumes unchanged.
- R10: `step_done` is high for exactly one cycle, in the cycle right after the last enabled cycle of a burst, and `busy` is low in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register address: 0 mode, 1 burst start, 2 push burst length, 3 halt arm mask |
| cfg_wdata | input | CNT_W | Register write data |
| fifo_push | input | 1 | Host wrote a word into the input queue |
| halt_n | input | NUM_PE | Active-low halt request per processing element |
| pause_req | input | 1 | Pause request from the host memory arbiter |
| pclk_en | output | 1 | Processing clock enable |
| busy | output | 1 | A counted burst is in progress |
| step_done | output | 1 | One-cycle burst completion pulse |

## Verification
The bound checker watches every cycle for four things: the pause gating the enable, a frozen busy state under pause, an always-on enable while a burst is pending, and a completion pulse that is single, follows an enabled cycle and never coincides with busy. The exact burst lengths, the ignored start and push commands, the persistence of the push burst length, and the three-cycle tail after an armed halt edge all depend on counting over many cycles. Only the bench's scenarios can show these, and it sweeps the burst length and each halt line in turn.

// File: rtl/stepclk_pkg.sv
package stepclk_pkg;

   typedef enum logic [1:0] {
      MD_HOLD  = 2'd0,
      MD_FREE  = 2'd1,
      MD_PUSH  = 2'd2,
      MD_HOLD3 = 2'd3
   } run_mode_e;

   localparam logic [1:0] RA_MODE   = 2'd0;
   localparam logic [1:0] RA_GO     = 2'd1;
   localparam logic [1:0] RA_PRESET = 2'd2;
   localparam logic [1:0] RA_ARM    = 2'd3;

endpackage

// File: rtl/stepclk_halt_det.sv
module stepclk_halt_det #(
   parameter int SYNC_STAGES = 0
) (
   input  logic clk,
   input  logic rst,
   input  logic line_n,
   input  logic arm,
   output logic fall
);

   logic line_s;
   logic prev_q;

   generate
      if (SYNC_STAGES < 0) begin : g_bad_sync
         $error("SYNC_STAGES must not be negative");
      end
      if (SYNC_STAGES == 0) begin : g_direct
         assign line_s = line_n;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] sh_q;
         always_ff @(posedge clk) begin
            if (rst) begin
               sh_q <= '1;
            end else begin
               sh_q[0] <= line_n;
               for (int i = 1; i < SYNC_STAGES; i++) begin
                  sh_q[i] <= sh_q[i-1];
               end
            end
         end
         assign line_s = sh_q[SYNC_STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) prev_q <= 1'b1;
      else     prev_q <= line_s;
   end

   assign fall = arm & prev_q & ~line_s;

endmodule

// File: rtl/stepclk_tail.sv
module stepclk_tail #(
   parameter int TAIL_LEN = 3
) (
   input  logic clk,
   input  logic rst,
   input  logic active,
   input  logic fall_any,
   input  logic pulse,
   output logic stop
);

   localparam int TW = $clog2(TAIL_LEN + 1);

   logic [TW-1:0] tail_q;

   generate
      if (TAIL_LEN < 1) begin : g_bad_tail
         $error("TAIL_LEN must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst || !active) begin
         tail_q <= '0;
      end else if (tail_q == '0) begin
         if (fall_any) tail_q <= TW'(TAIL_LEN);
      end else if (pulse) begin
         tail_q <= tail_q - 1'b1;
      end
   end

   assign stop = pulse && (tail_q == TW'(1));

endmodule

// File: rtl/stepclk_counter.sv
module stepclk_counter #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             clear,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic             pulse,
   output logic             busy,
   output logic             last
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (rst || clear) begin
         cnt_q <= '0;
      end else if (load) begin
         cnt_q <= load_val;
      end else if (pulse && busy) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign busy = (cnt_q != '0);
   assign last = (cnt_q == CNT_W'(1));

endmodule

// File: rtl/stepclk_ctrl.sv
module stepclk_ctrl
   import stepclk_pkg::*;
#(
   parameter int CNT_W      = 16,
   parameter int NUM_PE     = 3,
   parameter int HALT_TAIL  = 3,
   parameter int HALT_SYNC  = 0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              cfg_we,
   input  logic [1:0]        cfg_addr,
   input  logic [CNT_W-1:0]  cfg_wdata,
   input  logic              fifo_push,
   input  logic [NUM_PE-1:0] halt_n,
   input  logic              pause_req,
   output logic              pclk_en,
   output logic              busy,
   output logic              step_done
);

   generate
      if (CNT_W < 2) begin : g_bad_cnt
         $error("CNT_W must be at least 2");
      end
      if (NUM_PE < 1 || NUM_PE > CNT_W) begin : g_bad_pe
         $error("NUM_PE must lie in 1..CNT_W");
      end
   endgenerate

   logic              run_q, push_q, done_q;
   logic [NUM_PE-1:0] arm_q;
   logic [CNT_W-1:0]  preset_q;
   logic [NUM_PE-1:0] fall_v;
   run_mode_e         mode_v;
   logic              wr_mode, stop_wr, idle, go_load, push_load, active;
   logic              tail_stop, cnt_busy, cnt_last, cnt_load;
   logic [CNT_W-1:0]  cnt_val;

   assign mode_v    = run_mode_e'(cfg_wdata[1:0]);
   assign wr_mode   = cfg_we && (cfg_addr == RA_MODE);
   assign stop_wr   = wr_mode && (mode_v == MD_HOLD || mode_v == MD_HOLD3);
   assign idle      = !run_q && !cnt_busy;
   assign go_load   = cfg_we && (cfg_addr == RA_GO) && idle && (cfg_wdata != '0);
   assign push_load = fifo_push && push_q && idle && (preset_q != '0) && !go_load;
   assign cnt_load  = go_load || push_load;
   assign cnt_val   = go_load ? cfg_wdata : preset_q;
   assign active    = run_q || cnt_busy;
   assign pclk_en   = active && !pause_req;

   genvar k;
   generate
      for (k = 0; k < NUM_PE; k++) begin : g_halt
         stepclk_halt_det #(.SYNC_STAGES(HALT_SYNC)) u_det (
            .clk    (clk),
            .rst    (rst),
            .line_n (halt_n[k]),
            .arm    (arm_q[k]),
            .fall   (fall_v[k])
         );
      end
   endgenerate

   stepclk_tail #(.TAIL_LEN(HALT_TAIL)) u_tail (
      .clk      (clk),
      .rst      (rst),
      .active   (active),
      .fall_any (|fall_v),
      .pulse    (pclk_en),
      .stop     (tail_stop)
   );

   stepclk_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk      (clk),
      .rst      (rst),
      .clear    (stop_wr || tail_stop),
      .load     (cnt_load),
      .load_val (cnt_val),
      .pulse    (pclk_en),
      .busy     (cnt_busy),
      .last     (cnt_last)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         run_q    <= 1'b0;
         push_q   <= 1'b0;
         arm_q    <= '0;
         preset_q <= '0;
         done_q   <= 1'b0;
      end else begin
         done_q <= pclk_en && cnt_last && !stop_wr;
         if (wr_mode) begin
            run_q  <= (mode_v == MD_FREE);
            push_q <= (mode_v == MD_PUSH);
         end else if (tail_stop) begin
            run_q  <= 1'b0;
         end
         if (cfg_we && cfg_addr == RA_PRESET) preset_q <= cfg_wdata;
         if (cfg_we && cfg_addr == RA_ARM)    arm_q    <= cfg_wdata[NUM_PE-1:0];
      end
   end

   assign busy      = cnt_busy;
   assign step_done = done_q;

endmodule

// File: rtl/stepclk_ctrl_chk.sv
module stepclk_ctrl_chk (
   input logic clk,
   input logic rst,
   input logic cfg_we,
   input logic fifo_push,
   input logic pause_req,
   input logic pclk_en,
   input logic busy,
   input logic step_done
);

   a_r1_reset_quiet: assert property (@(posedge clk)
      rst |=> (!pclk_en && !busy && !step_done));

   a_r9_pause_gates: assert property (@(posedge clk) disable iff (rst)
      pause_req |-> !pclk_en);

   a_r9_pause_holds_count: assert property (@(posedge clk) disable iff (rst)
      (pause_req && !cfg_we && !fifo_push) |=> $stable(busy));

   a_r4_busy_enables: assert property (@(posedge clk) disable iff (rst)
      (busy && !pause_req) |-> pclk_en);

   a_r10_done_idle: assert property (@(posedge clk) disable iff (rst)
      step_done |-> !busy);

   a_r10_done_single: assert property (@(posedge clk) disable iff (rst)
      step_done |=> !step_done);

   a_r10_done_after_pulse: assert property (@(posedge clk) disable iff (rst)
      step_done |-> $past(pclk_en));

endmodule

bind stepclk_ctrl stepclk_ctrl_chk u_chk (
   .clk       (clk),
   .rst       (rst),
   .cfg_we    (cfg_we),
   .fifo_push (fifo_push),
   .pause_req (pause_req),
   .pclk_en   (pclk_en),
   .busy      (busy),
   .step_done (step_done)
);

// File: tb/stepclk_ctrl_test.sv
module stepclk_ctrl_test;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        cfg_we = 1'b0;
   logic [1:0]  cfg_addr = 2'd0;
   logic [15:0] cfg_wdata = 16'd0;
   logic        fifo_push = 1'b0;
   logic [2:0]  halt_n = 3'b111;
   logic        pause_req = 1'b0;
   logic        pclk_en, busy, step_done;

   int checks = 0, fails = 0;
   int cyc = 0, en_cnt = 0, done_cnt = 0, last_en = 0, last_done = 0, bad_done = 0;
   int base_en, base_d;

   always #2 clk = ~clk;

   stepclk_ctrl uut (
      .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .fifo_push(fifo_push), .halt_n(halt_n),
      .pause_req(pause_req), .pclk_en(pclk_en), .busy(busy), .step_done(step_done)
   );

   task automatic tick();
      @(negedge clk);
      cyc++;
      if (pclk_en) begin en_cnt++; last_en = cyc; end
      if (step_done) begin done_cnt++; last_done = cyc; if (busy) bad_done++; end
   endtask

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
      end
   endtask

   task automatic cfg(input logic [1:0] a, input int d);
      cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d[15:0];
      tick();
      cfg_we = 1'b0;
   endtask

   task automatic report();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      report();
      $finish;
   end

   initial begin
      repeat (3) tick();
      rst = 1'b0;
      tick();
      // R1: quiet after reset
      chk(!pclk_en, "R1 enable", pclk_en, 0);
      chk(!busy, "R1 busy", busy, 0);
      chk(!step_done, "R1 done", step_done, 0);
      // R1: halt lines disarmed after reset
      cfg(0, 1);
      halt_n[0] = 1'b0;
      repeat (8) tick();
      chk(pclk_en, "R1 disarmed halt", pclk_en, 1);
      // R2: free run counted
      base_en = en_cnt;
      repeat (30) tick();
      chk(en_cnt - base_en == 30, "R2 free run", en_cnt - base_en, 30);
      // R4: start ignored while free-running
      cfg(1, 5);
      chk(!busy, "R4 go in free run", busy, 0);
      // R3: stop write
      cfg(0, 0);
      chk(!pclk_en, "R3 stop", pclk_en, 1'b0);
      halt_n = 3'b111;
      tick();

      // R4 / R10: sweep of burst lengths
      for (int n = 1; n <= 24; n++) begin
         base_en = en_cnt; base_d = done_cnt;
         cfg(1, n);
         chk(busy, "R4 busy", busy, 1);
         repeat (n + 3) tick();
         chk(en_cnt - base_en == n, "R4 length", en_cnt - base_en, n);
         chk(done_cnt - base_d == 1, "R10 single done", done_cnt - base_d, 1);
         chk(last_done == last_en + 1, "R10 done timing", last_done, last_en + 1);
         chk(!busy, "R4 idle after", busy, 0);
      end
      cfg(1, 0);
      chk(!busy && !pclk_en, "R4 zero ignored", busy, 0);

      // R5: start during burst ignored
      base_en = en_cnt;
      cfg(1, 10);
      tick();
      cfg(1, 50);
      repeat (60) tick();
      chk(en_cnt - base_en == 10, "R5 busy go ignored", en_cnt - base_en, 10);

      // R3: abort mid-burst, no completion
      base_en = en_cnt; base_d = done_cnt;
      cfg(1, 20);
      repeat (5) tick();
      cfg(0, 3);
      chk(!busy && !pclk_en, "R3 abort", busy, 0);
      repeat (25) tick();
      chk(en_cnt - base_en == 6, "R3 abort count", en_cnt - base_en, 6);
      chk(done_cnt == base_d, "R3 no done", done_cnt - base_d, 0);

      // R6: push-triggered bursts
      cfg(2, 7);
      cfg(0, 2);
      chk(!pclk_en, "R3 push idle", pclk_en, 0);
      for (int r = 0; r < 3; r++) begin
         base_en = en_cnt; base_d = done_cnt;
         fifo_push = 1'b1; tick(); fifo_push = 1'b0;
         tick();
         fifo_push = 1'b1; tick(); fifo_push = 1'b0;
         repeat (12) tick();
         chk(en_cnt - base_en == 7, "R6 preset burst", en_cnt - base_en, 7);
         chk(done_cnt - base_d == 1, "R6 done", done_cnt - base_d, 1);
      end
      cfg(2, 3);
      base_en = en_cnt;
      fifo_push = 1'b1; tick(); fifo_push = 1'b0;
      repeat (8) tick();
      chk(en_cnt - base_en == 3, "R6 new preset", en_cnt - base_en, 3);
      cfg(0, 0);
      base_en = en_cnt;
      fifo_push = 1'b1; tick(); fifo_push = 1'b0;
      repeat (8) tick();
      chk(en_cnt == base_en && !busy, "R6 push outside mode", en_cnt - base_en, 0);

      // R7 / R8: each halt line in turn
      for (int pe = 0; pe < 3; pe++) begin
         cfg(3, 1 << pe);
         cfg(0, 1);
         halt_n[(pe + 1) % 3] = 1'b0;
         repeat (6) tick();
         chk(pclk_en, "R8 disarmed line", pclk_en, 1);
         base_en = en_cnt;
         halt_n[pe] = 1'b0;
         repeat (4) tick();
         chk(en_cnt - base_en == 3, "R7 tail", en_cnt - base_en, 3);
         chk(!pclk_en, "R7 stopped", pclk_en, 0);
         repeat (5) tick();
         chk(!pclk_en, "R7 free run cleared", pclk_en, 0);
         halt_n = 3'b111;
         tick();
      end
      // R7: halt during a burst
      cfg(3, 1);
      base_d = done_cnt;
      cfg(1, 20);
      repeat (2) tick();
      base_en = en_cnt;
      halt_n[0] = 1'b0;
      repeat (30) tick();
      chk(en_cnt - base_en == 3, "R7 burst tail", en_cnt - base_en, 3);
      chk(!busy && done_cnt == base_d, "R7 burst cleared", busy, 0);
      halt_n = 3'b111;
      cfg(3, 0);

      // R9: pause during burst
      base_en = en_cnt; base_d = done_cnt;
      cfg(1, 10);
      repeat (2) tick();
      pause_req = 1'b1;
      tick();
      chk(!pclk_en && busy, "R9 paused", pclk_en, 0);
      repeat (5) tick();
      chk(en_cnt - base_en == 3, "R9 frozen", en_cnt - base_en, 3);
      pause_req = 1'b0;
      repeat (15) tick();
      chk(en_cnt - base_en == 10, "R9 resumed total", en_cnt - base_en, 10);
      chk(done_cnt - base_d == 1, "R9 done", done_cnt - base_d, 1);
      // R9: pause in free run
      cfg(0, 1);
      pause_req = 1'b1; tick();
      chk(!pclk_en, "R9 free run pause", pclk_en, 0);
      pause_req = 1'b0; tick();
      chk(pclk_en, "R9 free run resume", pclk_en, 1);
      cfg(0, 0);

      chk(bad_done == 0, "R10 busy at done", bad_done, 0);
      report();
      $finish;
   end

endmodule